// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides which pending interrupt line, if any, should be raised to the processor. It looks at the pending-request vector, the mask vector and the in-service vector, together with a rotation offset that sets which line holds the highest priority. A request is raised only if it outranks everything already being serviced. When the nested option is on and the instance is the primary, the cascade line is left out of the in-service ranking, so a secondary instance can interrupt a handler that is already running for another line of that secondary.

The block also reports the highest-ranked line that is in service. An end-of-interrupt command that names no line uses this value to find its target. Both results are registered, so each one shows the inputs that were present at the previous rising clock edge. Register writes, the acknowledge handshake and cascading between instances are handled elsewhere.

Top module: `rpr_resolver`

## Requirements
- R1: While `rst_n` is low, `req_valid_o`, `req_line_o`, `isr_valid_o` and `isr_line_o` are all 0, whatever the other inputs are.
- R2: A line is a candidate only if its `irr_i` bit is 1 and its `mask_i` bit is 0. When there is no candidate, `req_valid_o` is 0. When `req_valid_o` is 1, `req_line_o` names a candidate line.
- R3: Priority level p belongs to line (p + `rot_ofs_i`) mod 8, and level 0 ranks highest. The winning candidate is the one with the lowest level, and `req_line_o` gives its line number.
- R4: The in-service level is the lowest level among the set bits of the in-service vector, using the same rotation. `req_valid_o` is 1 only if the winning level is strictly lower than the in-service level. An equal or higher level gives 0.
- R5: An empty in-service vector has level 8, meaning none, so any candidate wins.
- R6: When `nested_i` and `primary_i` are both 1, in-service bit 2 (the cascade line) is left out of the in-service level. If either input is 0, bit 2 counts like any other bit.
- R7: `isr_valid_o` is 1 when `isr_i` has any bit set. `isr_line_o` is then the line with the lowest rotated level in the full `isr_i`, with bit 2 never left out. When `isr_i` is empty, `isr_valid_o` is 0.
- R8: Every output updates on the rising edge of `clk` from the inputs present at that edge, and holds its value between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irr_i | input | 8 | Pending request bits, one per line |
| mask_i | input | 8 | Mask bits; a 1 blocks the line |
| isr_i | input | 8 | In-service bits, one per line |
| rot_ofs_i | input | 3 | Line that holds priority level 0 |
| nested_i | input | 1 | Nested mode enable |
| primary_i | input | 1 | Set on the primary instance |
| req_valid_o | output | 1 | A request should be raised |
| req_line_o | output | 3 | Line of the winning request |
| isr_valid_o | output | 1 | At least one line is in service |
| isr_line_o | output | 3 | Highest-ranked in-service line |

## Verification
The block holds no state apart from its output register. An error in the rotation, the masking or the in-service ranking therefore shows up at the ports one edge after the inputs that trigger it. It appears as a wrong line number, as a request raised while a higher-ranked line is in service, or as a request held back that should have been raised. The rotation offset moves every boundary, so the random sweep covers all eight offsets for each vector. The directed vectors target the equal-level case, the empty in-service vector and the cases where the cascade bit is left out or kept.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
    localparam int RPR_LINES   = 8;
    localparam int RPR_CASCADE = 2;
endpackage

// File: rtl/rpr_rotator.sv
module rpr_rotator #(
    parameter int N_LINES = 8,
    parameter int IDX_W   = 3
) (
    input  logic [N_LINES-1:0] vec_i,
    input  logic [IDX_W-1:0]   ofs_i,
    output logic [N_LINES-1:0] rot_o
);
    // rot_o[p] is the bit of the line that sits at priority level p
    always_comb begin
        rot_o = '0;
        for (int p = 0; p < N_LINES; p++) begin
            int idx;
            idx = p + int'(ofs_i);
            if (idx >= N_LINES) idx = idx - N_LINES;
            rot_o[p] = vec_i[idx];
        end
    end
endmodule

// File: rtl/rpr_first_set.sv
module rpr_first_set #(
    parameter int N_LINES = 8,
    parameter int LVL_W   = 4
) (
    input  logic [N_LINES-1:0] vec_i,
    output logic [LVL_W-1:0]   lvl_o
);
    // Lowest set index; N_LINES when the vector is empty
    always_comb begin
        lvl_o = LVL_W'(N_LINES);
        for (int p = N_LINES - 1; p >= 0; p--) begin
            if (vec_i[p]) lvl_o = LVL_W'(p);
        end
    end
endmodule

// File: rtl/rpr_resolver.sv
module rpr_resolver #(
    parameter int N_LINES      = rpr_pkg::RPR_LINES,
    parameter int CASCADE_LINE = rpr_pkg::RPR_CASCADE,
    localparam int IDX_W       = $clog2(N_LINES),
    localparam int LVL_W       = $clog2(N_LINES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irr_i,
    input  logic [N_LINES-1:0] mask_i,
    input  logic [N_LINES-1:0] isr_i,
    input  logic [IDX_W-1:0]   rot_ofs_i,
    input  logic               nested_i,
    input  logic               primary_i,
    output logic               req_valid_o,
    output logic [IDX_W-1:0]   req_line_o,
    output logic               isr_valid_o,
    output logic [IDX_W-1:0]   isr_line_o
);
    localparam int N_RANK = 3;   // candidates, in-service seen by compare, raw in-service

    logic [N_LINES-1:0] rank_vec [N_RANK];
    logic [N_LINES-1:0] rank_rot [N_RANK];
    logic [LVL_W-1:0]   rank_lvl [N_RANK];
    logic [N_LINES-1:0] busy_vec;

    always_comb begin
        busy_vec = isr_i;
        if (nested_i && primary_i) busy_vec[CASCADE_LINE] = 1'b0;
    end

    assign rank_vec[0] = irr_i & ~mask_i;
    assign rank_vec[1] = busy_vec;
    assign rank_vec[2] = isr_i;

    for (genvar g = 0; g < N_RANK; g++) begin : g_rank
        rpr_rotator #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_rot (
            .vec_i (rank_vec[g]),
            .ofs_i (rot_ofs_i),
            .rot_o (rank_rot[g])
        );
        rpr_first_set #(.N_LINES(N_LINES), .LVL_W(LVL_W)) u_first (
            .vec_i (rank_rot[g]),
            .lvl_o (rank_lvl[g])
        );
    end

    function automatic logic [IDX_W-1:0] level_to_line(input logic [LVL_W-1:0] lvl,
                                                       input logic [IDX_W-1:0] ofs);
        int s;
        s = int'(lvl) + int'(ofs);
        if (s >= N_LINES) s = s - N_LINES;
        return IDX_W'(s);
    endfunction

    logic             req_hit, busy_hit;
    logic [IDX_W-1:0] req_line, busy_line;

    // rank_lvl[1] never exceeds N_LINES, so a strict win implies a candidate exists
    assign req_hit   = rank_lvl[0] < rank_lvl[1];
    assign busy_hit  = rank_lvl[2] != LVL_W'(N_LINES);
    assign req_line  = req_hit  ? level_to_line(rank_lvl[0], rot_ofs_i) : '0;
    assign busy_line = busy_hit ? level_to_line(rank_lvl[2], rot_ofs_i) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_valid_o <= 1'b0;
            req_line_o  <= '0;
            isr_valid_o <= 1'b0;
            isr_line_o  <= '0;
        end else begin
            req_valid_o <= req_hit;
            req_line_o  <= req_line;
            isr_valid_o <= busy_hit;
            isr_line_o  <= busy_line;
        end
    end
endmodule

// File: rtl/rpr_resolver_chk.sv
module rpr_resolver_chk #(
    parameter int N_LINES      = 8,
    parameter int CASCADE_LINE = 2,
    localparam int IDX_W       = $clog2(N_LINES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_LINES-1:0] irr_i,
    input logic [N_LINES-1:0] mask_i,
    input logic [N_LINES-1:0] isr_i,
    input logic               nested_i,
    input logic               primary_i,
    input logic               req_valid_o,
    input logic [IDX_W-1:0]   req_line_o,
    input logic               isr_valid_o,
    input logic [IDX_W-1:0]   isr_line_o
);
    logic               armed;
    logic [N_LINES-1:0] prev_cand, prev_isr;
    logic               prev_shield;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed       <= 1'b0;
            prev_cand   <= '0;
            prev_isr    <= '0;
            prev_shield <= 1'b0;
        end else begin
            armed       <= 1'b1;
            prev_cand   <= irr_i & ~mask_i;
            prev_isr    <= isr_i;
            prev_shield <= nested_i && primary_i;
        end
    end

    AST_WINNER_IS_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && req_valid_o) |-> prev_cand[req_line_o]);                      // R2
    AST_NO_CANDIDATE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && prev_cand == '0) |-> !req_valid_o);                           // R2
    AST_IN_SERVICE_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && req_valid_o && isr_valid_o && !prev_shield) |-> req_line_o != isr_line_o); // R4
    AST_IDLE_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && prev_isr == '0 && prev_cand != '0) |-> req_valid_o);          // R5
    AST_HELPER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && prev_isr == '0) |-> !isr_valid_o);                            // R7
    AST_HELPER_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && isr_valid_o) |-> prev_isr[isr_line_o]);                       // R7
endmodule

bind rpr_resolver rpr_resolver_chk #(.N_LINES(N_LINES), .CASCADE_LINE(CASCADE_LINE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irr_i       (irr_i),
    .mask_i      (mask_i),
    .isr_i       (isr_i),
    .nested_i    (nested_i),
    .primary_i   (primary_i),
    .req_valid_o (req_valid_o),
    .req_line_o  (req_line_o),
    .isr_valid_o (isr_valid_o),
    .isr_line_o  (isr_line_o)
);

// File: tb/test_rpr_resolver.sv
module test_rpr_resolver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irr = '0, mask = '0, isr = '0;
    logic [2:0] ofs = '0;
    logic       nested = 1'b0, primary = 1'b0;
    logic       req_valid, isr_valid;
    logic [2:0] req_line, isr_line;
    int         n_run = 0, n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    rpr_resolver i_rpr_resolver (
        .clk(clk), .rst_n(rst_n), .irr_i(irr), .mask_i(mask), .isr_i(isr),
        .rot_ofs_i(ofs), .nested_i(nested), .primary_i(primary),
        .req_valid_o(req_valid), .req_line_o(req_line),
        .isr_valid_o(isr_valid), .isr_line_o(isr_line)
    );

    // {irr, mask, isr, ofs, nested, primary, exp_req_valid, exp_req_line, exp_isr_valid, exp_isr_line}
    localparam int NV = 14;
    localparam logic [39:0] VEC [NV] = '{
        {8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0}, // R2 nothing pending
        {8'h10, 8'h10, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0}, // R2 masked
        {8'h28, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 3'd3, 1'b0, 3'd0}, // R3
        {8'h28, 8'h00, 8'h00, 3'd4, 1'b0, 1'b0, 1'b1, 3'd5, 1'b0, 3'd0}, // R3 rotated
        {8'h81, 8'h00, 8'h00, 3'd1, 1'b0, 1'b0, 1'b1, 3'd7, 1'b0, 3'd0}, // R3 wrap
        {8'h08, 8'h00, 8'h08, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd3}, // R4 equal level
        {8'h08, 8'h00, 8'h02, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd1}, // R4 lower rank
        {8'h02, 8'h00, 8'h08, 3'd0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b1, 3'd3}, // R4 beats
        {8'h10, 8'h00, 8'h04, 3'd0, 1'b1, 1'b1, 1'b1, 3'd4, 1'b1, 3'd2}, // R6 excluded
        {8'h10, 8'h00, 8'h04, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2}, // R6 secondary
        {8'h10, 8'h00, 8'h04, 3'd0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 3'd2}, // R6 not nested
        {8'h10, 8'h00, 8'h24, 3'd0, 1'b1, 1'b1, 1'b1, 3'd4, 1'b1, 3'd2}, // R6 other bits count
        {8'hFF, 8'h00, 8'h00, 3'd7, 1'b0, 1'b0, 1'b1, 3'd7, 1'b0, 3'd0}, // R5 idle
        {8'h00, 8'h00, 8'h21, 3'd3, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd5}  // R7 rotated helper
    };

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h (irr=%h mask=%h isr=%h ofs=%0d n=%b p=%b)",
                     req, got, exp, irr, mask, isr, ofs, nested, primary);
        end
    endtask

    function automatic int ref_level(input logic [7:0] v, input logic [2:0] o);
        for (int p = 0; p < 8; p++) if (v[(p + o) % 8]) return p;
        return 8;
    endfunction

    task automatic apply_and_check(input string req, input logic ev, input logic [2:0] el,
                                   input logic eiv, input logic [2:0] eil);
        @(negedge clk);
        check(req, {req_valid, req_valid ? req_line : 3'd0}, {ev, ev ? el : 3'd0});
        check("R7", {isr_valid, isr_valid ? isr_line : 3'd0}, {eiv, eiv ? eil : 3'd0});
    endtask

    initial begin : watchdog
        #600000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: outputs held low in reset with busy inputs
        irr = 8'hFF; isr = 8'h01;
        repeat (3) @(negedge clk);
        check("R1", {req_valid, 3'd0}, 4'h0);
        check("R1", {isr_valid, 3'd0}, 4'h0);
        check("R1", {1'b0, req_line | isr_line}, 4'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            {irr, mask, isr, ofs, nested, primary} = VEC[i][39:8];
            apply_and_check("R2/R3/R4/R5/R6", VEC[i][7], VEC[i][6:4], VEC[i][3], VEC[i][2:0]);
        end

        // R8: output holds until the next edge
        irr = 8'h01; mask = '0; isr = '0; ofs = '0; nested = 0; primary = 0;
        @(negedge clk);
        irr = 8'h40;
        #1;
        check("R8", {req_valid, req_line}, {1'b1, 3'd0});
        @(negedge clk);
        check("R8", {req_valid, req_line}, {1'b1, 3'd6});

        // Random sweep over all offsets: R3 R4 R6 R7
        for (int i = 0; i < 300; i++) begin
            logic [7:0] r_irr, r_mask, r_isr, busy;
            logic       r_n, r_p;
            r_irr  = 8'($urandom);
            r_mask = 8'($urandom) & 8'($urandom);
            r_isr  = 8'($urandom) & 8'($urandom) & 8'($urandom);
            r_n    = 1'($urandom);
            r_p    = 1'($urandom);
            for (int o = 0; o < 8; o++) begin
                int cl, bl, il;
                logic ev, eiv;
                busy = r_isr;
                if (r_n && r_p) busy[2] = 1'b0;
                cl  = ref_level(r_irr & ~r_mask, 3'(o));
                bl  = ref_level(busy, 3'(o));
                il  = ref_level(r_isr, 3'(o));
                ev  = cl < bl;
                eiv = il < 8;
                irr = r_irr; mask = r_mask; isr = r_isr; ofs = 3'(o);
                nested = r_n; primary = r_p;
                apply_and_check("R3/R4/R6", ev, 3'((cl + o) % 8), eiv, 3'((il + o) % 8));
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule